// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by walking a two-level radix page table in memory. A translation control word gives three things: an enable bit, an address-space tag, and the page number of the root table. When translation is off, the address passes through unchanged and no memory is read. When it is on, the walker fetches one or two 32-bit page table entries over a simple memory read port. It checks each entry's validity and permission bits against the access type of the request, which is read, write or execute. It then answers with a physical address or a page fault.

The virtual address splits into a 10-bit first-level index, a 10-bit second-level index and a 12-bit page offset. A first-level entry can point to a second-level table, or it can be a leaf that maps a 4 MiB superpage. A second-level entry must be a leaf that maps a 4 KiB page. Only one walk is in flight at a time. A new request is taken only while the walker is idle, and the control word is captured when the request is accepted.

Top module: `pt_walker`

## Requirements
- R1: After reset, rsp_valid_o and mem_req_o are 0 and req_ready_o is 1.
- R2: When bit 31 of xlat_cfg_i is 0 at acceptance, the response comes in the cycle after acceptance with rsp_fault_o=0 and rsp_paddr_o equal to the virtual address zero-extended to 34 bits, and no memory read is issued.
- R3: With translation on, the first read address is {xlat_cfg_i[21:0], 12'h000} + 4*VA[31:22].
- R4: A valid first-level entry with R, W and X all 0 (entry bits 1, 2, 3) is a table pointer. The second read address is then {entry[31:10], 12'h000} + 4*VA[21:12].
- R5: A valid second-level leaf gives rsp_paddr_o = {entry[31:10], VA[11:0]}.
- R6: A valid first-level leaf is a 4 MiB superpage. If entry[19:10] is 0, rsp_paddr_o = {entry[31:20], VA[21:0]}. Otherwise the access faults.
- R7: An entry at either level with V (bit 0) clear, or with W set and R clear, causes a fault.
- R8: A table pointer found at the second level causes a fault, and a walk never issues more than two reads.
- R9: req_kind_i 0 (read) requires R, 1 (write) requires W, 2 (execute) requires X, and 3 is treated as read. A leaf without the required bit causes a fault.
- R10: A faulting response has rsp_fault_o=1 and rsp_paddr_o=0, and no read follows the faulting entry.
- R11: Bits [30:22] of xlat_cfg_i, the address-space tag, do not change any read address or response.
- R12: mem_req_o and mem_addr_o hold steady until mem_valid_i. rsp_valid_o is a one-cycle pulse, and req_ready_o is 0 from acceptance until after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlat_cfg_i | input | 32 | Translation control: enable [31], address-space tag [30:22], root page number [21:0] |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_kind_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| mem_req_o | output | 1 | Entry read request, held until mem_valid_i |
| mem_addr_o | output | 34 | Physical byte address of the entry |
| mem_valid_i | input | 1 | Entry data valid on mem_rdata_i |
| mem_rdata_i | input | 32 | Page table entry read from memory |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 1 | Page fault |
| rsp_paddr_o | output | 34 | Physical address, zero on fault |

## Verification
The bench builds the walker with its default package widths: the 10+10+12 split, 32-bit entries and a 34-bit physical space. With these widths, pointer entries, 4 KiB leaves, aligned and misaligned superpages, and all three access types can each be reached within a few hundred random walks. Memory answers after a latency of zero to three cycles, so the hold rules on the read port are exercised with and without wait states. Random control words vary the address-space tag to expose any dependence on it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned VPN_W  = 10;
  localparam int unsigned PPN0_W = 10;
  localparam int unsigned PPN1_W = 12;
  localparam int unsigned PPN_W  = PPN0_W + PPN1_W;
  localparam int unsigned PA_W   = PPN_W + OFF_W;
  localparam int unsigned PTE_W  = 32;
  localparam int unsigned CFG_W  = 32;
  localparam int unsigned ENTRY_SHIFT = 2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_DONE = 2'd2
  } st_e;

  typedef struct packed {
    logic [PPN1_W-1:0] ppn1;
    logic [PPN0_W-1:0] ppn0;
    logic [1:0]        sw;
    logic              d;
    logic              a;
    logic              g;
    logic              u;
    logic              x;
    logic              w;
    logic              r;
    logic              v;
  } pte_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [PA_W-1:0] base_i,
  input  logic [VA_W-1:0] va_i,
  input  logic            lvl2_i,
  output logic [PA_W-1:0] addr_o
);
  localparam int unsigned PAD_W = PA_W - VPN_W - ENTRY_SHIFT;

  logic [VPN_W-1:0] idx;

  always_comb begin
    if (lvl2_i) idx = va_i[OFF_W +: VPN_W];
    else        idx = va_i[OFF_W + VPN_W +: VPN_W];
  end

  assign addr_o = base_i + {{PAD_W{1'b0}}, idx, {ENTRY_SHIFT{1'b0}}};
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic             lvl2_i,
  input  acc_e             kind_i,
  input  logic [VA_W-1:0]  va_i,
  output logic             descend_o,
  output logic             fault_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [PA_W-1:0]  next_base_o
);
  pte_t pte;
  logic is_ptr, malformed, misaligned, perm_ok;
  logic pte_unused;

  assign pte        = pte_t'(pte_i);
  assign pte_unused = ^{pte.sw, pte.d, pte.a, pte.g, pte.u};

  assign is_ptr     = ~pte.r & ~pte.w & ~pte.x;
  assign malformed  = ~pte.v | (pte.w & ~pte.r);
  assign misaligned = ~lvl2_i & (pte.ppn0 != '0);

  always_comb begin
    unique case (kind_i)
      ACC_WRITE: perm_ok = pte.w;
      ACC_EXEC:  perm_ok = pte.x;
      default:   perm_ok = pte.r;
    endcase
  end

  assign descend_o = ~malformed & is_ptr & ~lvl2_i;
  assign fault_o   = malformed | (is_ptr & lvl2_i) | (~is_ptr & (misaligned | ~perm_ok));

  // superpage takes its middle field from the VA
  always_comb begin
    if (lvl2_i) pa_o = {pte.ppn1, pte.ppn0, va_i[OFF_W-1:0]};
    else        pa_o = {pte.ppn1, va_i[OFF_W +: PPN0_W], va_i[OFF_W-1:0]};
  end

  assign next_base_o = {pte.ppn1, pte.ppn0, {OFF_W{1'b0}}};
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  va_i,
  input  acc_e             kind_i,
  input  logic             mem_valid_i,
  input  logic             descend_i,
  input  logic             fault_i,
  input  logic [PA_W-1:0]  pa_i,
  input  logic [PA_W-1:0]  next_base_i,
  output logic             req_ready_o,
  output logic             mem_req_o,
  output logic [VA_W-1:0]  va_o,
  output acc_e             kind_o,
  output logic             lvl2_o,
  output logic [PA_W-1:0]  base_o,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [PA_W-1:0]  rsp_paddr_o
);
  localparam int unsigned EN_BIT = CFG_W - 1;
  localparam int unsigned ZX_W   = PA_W - VA_W;

  st_e             state_q;
  logic [VA_W-1:0] va_q;
  acc_e            kind_q;
  logic            lvl2_q;
  logic [PA_W-1:0] base_q, paddr_q;
  logic            fault_q;
  logic            asid_unused;

  assign asid_unused = ^cfg_i[EN_BIT-1:PPN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      kind_q  <= ACC_READ;
      lvl2_q  <= 1'b0;
      base_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q   <= va_i;
          kind_q <= kind_i;
          lvl2_q <= 1'b0;
          base_q <= {cfg_i[PPN_W-1:0], {OFF_W{1'b0}}};
          if (cfg_i[EN_BIT]) begin
            state_q <= ST_WALK;
          end else begin
            state_q <= ST_DONE;
            fault_q <= 1'b0;
            paddr_q <= {{ZX_W{1'b0}}, va_i};
          end
        end
        ST_WALK: if (mem_valid_i) begin
          if (descend_i) begin
            lvl2_q <= 1'b1;
            base_q <= next_base_i;
          end else begin
            state_q <= ST_DONE;
            fault_q <= fault_i;
            paddr_q <= fault_i ? '0 : pa_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_WALK);
  assign rsp_valid_o = (state_q == ST_DONE);
  assign rsp_fault_o = fault_q;
  assign rsp_paddr_o = paddr_q;
  assign va_o        = va_q;
  assign kind_o      = kind_q;
  assign lvl2_o      = lvl2_q;
  assign base_o      = base_q;

  AST_BYPASS_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i && !cfg_i[EN_BIT]) |=> (rsp_valid_o && !mem_req_o)); // R2
  AST_FAULT_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_paddr_o == '0)); // R10
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o)); // R12
  AST_TWO_READS_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i && lvl2_q) |=> !mem_req_o); // R8
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] xlat_cfg_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       req_kind_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_valid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [PA_W-1:0]  rsp_paddr_o
);
  logic [VA_W-1:0] va_q;
  acc_e            kind_q;
  logic            lvl2_q;
  logic [PA_W-1:0] base_q, chk_pa, chk_base;
  logic            chk_descend, chk_fault;

  ptw_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (xlat_cfg_i),
    .req_valid_i (req_valid_i),
    .va_i        (req_vaddr_i),
    .kind_i      (acc_e'(req_kind_i)),
    .mem_valid_i (mem_valid_i),
    .descend_i   (chk_descend),
    .fault_i     (chk_fault),
    .pa_i        (chk_pa),
    .next_base_i (chk_base),
    .req_ready_o (req_ready_o),
    .mem_req_o   (mem_req_o),
    .va_o        (va_q),
    .kind_o      (kind_q),
    .lvl2_o      (lvl2_q),
    .base_o      (base_q),
    .rsp_valid_o (rsp_valid_o),
    .rsp_fault_o (rsp_fault_o),
    .rsp_paddr_o (rsp_paddr_o)
  );

  ptw_addr_gen u_addr (
    .base_i (base_q),
    .va_i   (va_q),
    .lvl2_i (lvl2_q),
    .addr_o (mem_addr_o)
  );

  ptw_pte_check u_check (
    .pte_i       (mem_rdata_i),
    .lvl2_i      (lvl2_q),
    .kind_i      (kind_q),
    .va_i        (va_q),
    .descend_o   (chk_descend),
    .fault_o     (chk_fault),
    .pa_o        (chk_pa),
    .next_base_o (chk_base)
  );

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R12
  AST_ENTRY_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[ENTRY_SHIFT-1:0] == '0)); // R3
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o); // R12
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] vaddr = '0;
  logic [1:0]  kind = '0;
  logic        mem_req;
  logic [33:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault;
  logic [33:0] rsp_paddr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pt_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .xlat_cfg_i(cfg),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(vaddr), .req_kind_i(kind),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit perm(input logic [31:0] p, input logic [1:0] k);
    if (k == 2'd1) return p[2];
    if (k == 2'd2) return p[3];
    return p[1];
  endfunction

  function automatic void ref_walk(
    input  logic [31:0] c, input logic [31:0] va, input logic [1:0] k,
    input  logic [31:0] p1, input logic [31:0] p2,
    output bit f, output logic [33:0] pa, output int n,
    output logic [33:0] a1, output logic [33:0] a2, output string tag);
    f = 0; pa = '0; n = 0; a1 = '0; a2 = '0; tag = "R2";
    if (!c[31]) begin
      pa = {2'b00, va};
      return;
    end
    n = 1;
    a1 = {c[21:0], 12'h000} + 34'(va[31:22]) * 34'd4;
    if (!p1[0] || (p1[2] && !p1[1])) begin
      f = 1; tag = "R7";
    end else if (p1[3:1] == 3'b000) begin
      n = 2;
      a2 = {p1[31:10], 12'h000} + 34'(va[21:12]) * 34'd4;
      if (!p2[0] || (p2[2] && !p2[1])) begin f = 1; tag = "R7"; end
      else if (p2[3:1] == 3'b000) begin f = 1; tag = "R8"; end
      else if (!perm(p2, k)) begin f = 1; tag = "R9"; end
      else begin pa = {p2[31:10], va[11:0]}; tag = "R5"; end
    end else begin
      tag = "R6";
      if (p1[19:10] != 10'd0) f = 1;
      else if (!perm(p1, k)) begin f = 1; tag = "R9"; end
      else pa = {p1[31:20], va[21:0]};
    end
    if (f) pa = '0;
  endfunction

  task automatic run(input logic [31:0] c, input logic [31:0] va, input logic [1:0] k,
                     input logic [31:0] p1, input logic [31:0] p2, input int lat,
                     output logic [33:0] got_pa, output bit got_f);
    bit          ef;
    logic [33:0] epa, ea1, ea2, seen;
    int          en, reads, cyc;
    bit          got;
    string       tag;
    ref_walk(c, va, k, p1, p2, ef, epa, en, ea1, ea2, tag);
    @(negedge clk);
    cfg = c; vaddr = va; kind = k; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cfg = {$urandom} ^ 32'h8000_0000;
    reads = 0; got = 0; cyc = 0; got_pa = '0; got_f = 0;
    while (!got && cyc < 60) begin
      if (rsp_valid) begin
        got = 1; got_pa = rsp_paddr; got_f = rsp_fault;
      end else if (mem_req) begin
        seen = mem_addr;
        chk("R12", "ready low while walking", 64'(req_ready), 64'd0);
        if (reads == 0) chk("R3", "first entry address", 64'(seen), 64'(ea1));
        else if (reads == 1) chk("R4", "second entry address", 64'(seen), 64'(ea2));
        else chk("R8", "extra read", 64'(reads), 64'd2);
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          cyc++;
          chk("R12", "request held", 64'({mem_req, mem_addr}), 64'({1'b1, seen}));
        end
        mem_rdata = (reads == 0) ? p1 : p2;
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
        mem_rdata = $urandom;
        reads++; cyc++;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!got) chk(tag, "response timeout", 64'd0, 64'd1);
    chk(ef ? "R10" : tag, "read count", 64'(reads), 64'(en));
    chk(tag, "fault flag", 64'(got_f), 64'(ef));
    chk(ef ? "R10" : tag, "physical address", 64'(got_pa), 64'(epa));
    @(negedge clk);
    chk("R12", "response pulse ends", 64'({rsp_valid, req_ready}), 64'({1'b0, 1'b1}));
  endtask

  function automatic logic [31:0] rand_pte();
    logic [31:0] p;
    p = $urandom;
    p[0] = (($urandom % 8) != 0);
    if (($urandom % 3) == 0) p[3:1] = 3'b000;
    if (($urandom % 2) == 0) p[19:10] = '0;
    return p;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [33:0] pa_a, pa_b;
    bit          f_a, f_b;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", 64'({rsp_valid, mem_req, req_ready}), 64'({1'b0, 1'b0, 1'b1}));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", 64'({rsp_valid, mem_req, req_ready}), 64'({1'b0, 1'b0, 1'b1}));

    // R2 bypass
    run(32'h7FFF_FFFF, 32'hDEAD_BEEF, 2'd1, 32'h0, 32'h0, 0, pa_a, f_a);
    // R3 R4 R5 pointer then 4 KiB read leaf
    run(32'h8000_1234, 32'h1234_5678, 2'd0, 32'h0ABC_D001, 32'h1357_9C03, 2, pa_a, f_a);
    // R6 aligned superpage, execute
    run(32'h8000_0042, 32'hFFC0_0ABC, 2'd2, 32'hFFF0_000B, 32'h0, 1, pa_a, f_a);
    // R6 misaligned superpage
    run(32'h8000_0042, 32'h0040_0000, 2'd0, 32'hABC0_0403, 32'h0, 0, pa_a, f_a);
    // R7 invalid first level, W-only first level, invalid second level
    run(32'h8000_0001, 32'h0000_1000, 2'd0, 32'h0000_040E, 32'h0, 0, pa_a, f_a);
    run(32'h8000_0001, 32'h0000_1000, 2'd1, 32'h0000_0005, 32'h0, 3, pa_a, f_a);
    run(32'h8000_0001, 32'h0000_1000, 2'd0, 32'h0000_0401, 32'h0000_040E, 0, pa_a, f_a);
    // R8 pointer at second level
    run(32'h8000_0001, 32'h0000_1000, 2'd0, 32'h0000_0401, 32'h0000_0801, 1, pa_a, f_a);
    // R9 write to read-only, exec on read-write, kind 3 as read
    run(32'h8000_0001, 32'h0000_1000, 2'd1, 32'h0000_0401, 32'h0000_0803, 0, pa_a, f_a);
    run(32'h8000_0001, 32'h0000_1000, 2'd2, 32'h0000_0401, 32'h0000_0807, 0, pa_a, f_a);
    run(32'h8000_0001, 32'h0000_1000, 2'd3, 32'h0000_0401, 32'h0000_0803, 0, pa_a, f_a);
    // R11 address-space tag has no effect
    run(32'h8000_0077, 32'h0345_6789, 2'd0, 32'h0000_4401, 32'h2222_2C03, 1, pa_a, f_a);
    run(32'hFFC0_0077, 32'h0345_6789, 2'd0, 32'h0000_4401, 32'h2222_2C03, 2, pa_b, f_b);
    chk("R11", "tag independent address", 64'(pa_b), 64'(pa_a));
    chk("R11", "tag independent fault", 64'(f_b), 64'(f_a));

    for (int t = 0; t < 400; t++) begin
      logic [31:0] c;
      c = $urandom;
      if (($urandom % 8) != 0) c[31] = 1'b1;
      run(c, $urandom, 2'($urandom % 4), rand_pte(), rand_pte(), $urandom % 4, pa_a, f_a);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule